// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block multiplies two 32-bit binary floating-point operands. Each operand has a sign bit, an 8-bit exponent offset by 127 and a 23-bit fraction. The block restores the hidden leading one, forms the full 48-bit significand product and normalizes it. It then rounds to nearest, with ties going to an even result. If rounding carries out of the significand, it renormalizes. It packs the result and raises one of three flags: exponent overflow, exponent underflow, or an invalid operation.

A product is requested by asserting `in_valid` with both operands for one clock. The packed result and its flags appear one clock later from a single output register, qualified by `out_valid`. A new pair may be presented on every clock. Subnormal operands are read as zero. Results too small for a normal encoding become a zero of the correct sign. NaN results always carry the one canonical quiet encoding, 0x7FC00000.

Top module: `fp32_mul`

## Requirements
- R1: When `in_valid` is high at a rising edge, `out_valid` is high after that edge together with that pair's result; otherwise `out_valid` is low after the edge.
- R2: For every non-NaN result, bit 31 of `y` equals the XOR of bit 31 of `a` and `b`.
- R3: For normal operands the biased result exponent is ea + eb - 127, plus one when bit 47 of the 48-bit significand product is set (2.0 x 3.0 = 0x40C00000, 1.5 x 1.5 = 0x40100000).
- R4: The significand is rounded to nearest using guard, round and sticky bits, and an exact halfway case rounds to an even least significant bit (0x3F800001 x 0x3FC00000 = 0x3FC00002; 0x3F800003 x 0x3FC00000 = 0x3FC00004).
- R5: When rounding carries out of the 24-bit significand, the fraction becomes zero and the exponent increases by one (0x3F7FFFFE x 0x3F800001 = 0x3F800000).
- R6: A final biased exponent of 255 or more yields an infinity of the result sign (exponent field 0xFF, fraction 0) with `ovf` set. This includes overflow caused only by the rounding carry: 0x7F7FFFFE x 0x3F800001 = 0x7F800000.
- R7: A final biased exponent of 0 or less yields a zero of the result sign with `unf` set (0x80800000 x 0x3F000000 = 0x80000000).
- R8: An operand with exponent field 0 is treated as zero, whatever its fraction is.
- R9: If either operand is a NaN (exponent 0xFF, nonzero fraction), `y` is 0x7FC00000 with all flags clear.
- R10: Zero times infinity gives `y` = 0x7FC00000 with `inv` set.
- R11: Infinity times a nonzero non-NaN value gives a signed infinity, and zero times a finite value gives a signed zero, both with all flags clear.
- R12: While reset is held, `out_valid`, `y` and all flags are zero. At most one flag is set at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair is present this cycle |
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| out_valid | output | 1 | Result registers hold a new product |
| y | output | 32 | Packed product |
| ovf | output | 1 | Exponent overflow, result is infinity |
| unf | output | 1 | Exponent underflow, result is zero |
| inv | output | 1 | Invalid operation (zero times infinity) |

## Verification
Rounding and the exponent range check can act on the same product. This happens when the carry out of a round-up pushes an exponent of 254 to 255, so an unrounded finite result turns into an overflow. The bench provokes this with 0x7F7FFFFE x 0x3F800001 and expects +infinity with `ovf` set. It also applies the neighbour with one lower exponent, which rounds up to exactly 2^127 with no flag. A stage that tests range before rounding would miss the first case. One that ignores the carry would produce a wrong exponent in both.

// File: rtl/fp32_mul.sv
module fp32_mul #(
  parameter int EW = 8,
  parameter int FW = 23
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [EW+FW:0]      a,
  input  logic [EW+FW:0]      b,
  output logic                out_valid,
  output logic [EW+FW:0]      y,
  output logic                ovf,
  output logic                unf,
  output logic                inv
);
  localparam int MW   = FW + 1;
  localparam int PW   = 2 * MW;
  localparam int XW   = EW + 2;
  localparam int BIAS = (1 << (EW - 1)) - 1;
  localparam logic [EW-1:0] EMAX = '1;

  logic [EW-1:0] ea, eb;
  logic [FW-1:0] fa, fb;
  assign ea = a[EW+FW-1:FW];
  assign eb = b[EW+FW-1:FW];
  assign fa = a[FW-1:0];
  assign fb = b[FW-1:0];

  logic a_zero, b_zero, a_inf, b_inf, a_nan, b_nan, sgn;
  assign a_zero = (ea == '0);
  assign b_zero = (eb == '0);
  assign a_inf  = (ea == EMAX) && (fa == '0);
  assign b_inf  = (eb == EMAX) && (fb == '0);
  assign a_nan  = (ea == EMAX) && (fa != '0);
  assign b_nan  = (eb == EMAX) && (fb != '0);
  assign sgn    = a[EW+FW] ^ b[EW+FW];

  logic [PW-1:0] prod;
  assign prod = {{MW{1'b0}}, 1'b1, fa} * {{MW{1'b0}}, 1'b1, fb};

  logic          hi;
  logic [MW-1:0] kept;
  logic          g, r, st, up;
  assign hi   = prod[PW-1];
  assign kept = hi ? prod[PW-1:MW] : prod[PW-2:MW-1];
  assign g    = hi ? prod[MW-1] : prod[MW-2];
  assign r    = hi ? prod[MW-2] : prod[MW-3];
  assign st   = hi ? |prod[MW-3:0] : |prod[MW-4:0];
  assign up   = g & (r | st | kept[0]);

  logic [MW:0]   rnd;
  logic          cy;
  logic [FW-1:0] frac;
  assign rnd  = {1'b0, kept} + {{MW{1'b0}}, up};
  assign cy   = rnd[MW];
  assign frac = cy ? rnd[MW-1:1] : rnd[FW-1:0];

  logic signed [XW-1:0] efin;
  assign efin = $signed({2'b00, ea}) + $signed({2'b00, eb}) - $signed(XW'(BIAS))
              + $signed({{(XW-1){1'b0}}, hi}) + $signed({{(XW-1){1'b0}}, cy});

  logic [EW+FW:0] y_n;
  logic           ovf_n, unf_n, inv_n;
  always_comb begin
    y_n   = '0;
    ovf_n = 1'b0;
    unf_n = 1'b0;
    inv_n = 1'b0;
    if (a_nan || b_nan || (a_zero && b_inf) || (b_zero && a_inf)) begin
      y_n   = {1'b0, EMAX, 1'b1, {(FW-1){1'b0}}};
      inv_n = !(a_nan || b_nan);
    end else if (a_inf || b_inf) begin
      y_n = {sgn, EMAX, {FW{1'b0}}};
    end else if (a_zero || b_zero) begin
      y_n = {sgn, {(EW+FW){1'b0}}};
    end else if (efin >= $signed({2'b00, EMAX})) begin
      y_n   = {sgn, EMAX, {FW{1'b0}}};
      ovf_n = 1'b1;
    end else if (efin <= 0) begin
      y_n   = {sgn, {(EW+FW){1'b0}}};
      unf_n = 1'b1;
    end else begin
      y_n = {sgn, efin[EW-1:0], frac};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      y         <= '0;
      ovf       <= 1'b0;
      unf       <= 1'b0;
      inv       <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        y   <= y_n;
        ovf <= ovf_n;
        unf <= unf_n;
        inv <= inv_n;
      end
    end
  end
endmodule

// File: rtl/fp32_mul_chk.sv
module fp32_mul_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [31:0] a,
  input logic [31:0] b,
  input logic        out_valid,
  input logic [31:0] y,
  input logic        ovf,
  input logic        unf,
  input logic        inv
);
  logic y_nan;
  assign y_nan = (y[30:23] == 8'hFF) && (y[22:0] != 23'd0);

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_sign_xor_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (y_nan || (y[31] == ($past(a[31]) ^ $past(b[31])))));
  assert_ovf_is_inf_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && ovf) |-> (y[30:0] == 31'h7F800000));
  assert_unf_is_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && unf) |-> (y[30:0] == 31'd0));
  assert_nan_input_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ((a[30:23] == 8'hFF && a[22:0] != 0) || (b[30:23] == 8'hFF && b[22:0] != 0)))
    |=> (y == 32'h7FC00000 && !inv));
  assert_inv_is_qnan_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && inv) |-> (y == 32'h7FC00000));
  assert_one_flag_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ovf, unf, inv}));
endmodule

bind fp32_mul fp32_mul_chk u_fp32_mul_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a(a), .b(b),
  .out_valid(out_valid), .y(y), .ovf(ovf), .unf(unf), .inv(inv)
);

// File: tb/fp32_mul_bench.sv
module fp32_mul_bench;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] a = '0, b = '0;
  logic        out_valid, ovf, unf, inv;
  logic [31:0] y;

  int applied = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] y;
    logic [2:0]  fl;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  fp32_mul u_fp32_mul (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a(a), .b(b),
    .out_valid(out_valid), .y(y), .ovf(ovf), .unf(unf), .inv(inv)
  );

  task automatic drive(input logic [31:0] xa, input logic [31:0] xb,
                       input logic [31:0] ey, input logic [2:0] efl, input string tag);
    exp_t e;
    e.y = ey; e.fl = efl; e.tag = tag;
    sb.push_back(e);
    a = xa; b = xb; in_valid = 1'b1;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    a = 32'hDEADBEEF; b = 32'h12345678;
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (sb.size() == 0) begin
        bad++;
        $display("FAIL R1 unexpected out_valid: actual y=%h expected no result", y);
      end else begin
        exp_t e;
        e = sb.pop_front();
        applied++;
        if (y !== e.y || {ovf, unf, inv} !== e.fl) begin
          bad++;
          $display("FAIL %s: actual y=%h flags=%b expected y=%h flags=%b",
                   e.tag, y, {ovf, unf, inv}, e.y, e.fl);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  end

  initial begin
    a = 32'hFFFFFFFF; b = 32'hFFFFFFFF; in_valid = 1'b1;
    repeat (3) @(negedge clk);
    applied++;
    if (out_valid !== 1'b0 || y !== 32'd0 || {ovf, unf, inv} !== 3'b000) begin
      bad++;
      $display("FAIL R12 reset: actual v=%b y=%h flags=%b expected 0 0 000",
               out_valid, y, {ovf, unf, inv});
    end
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    drive(32'h40000000, 32'h40400000, 32'h40C00000, 3'b000, "R3 2x3");
    drive(32'h3FC00000, 32'h3FC00000, 32'h40100000, 3'b000, "R3 1.5x1.5 high product bit");
    drive(32'hBFC00000, 32'h40000000, 32'hC0400000, 3'b000, "R2 negative times positive");
    drive(32'hBF800000, 32'hC0000000, 32'h40000000, 3'b000, "R2 two negatives");
    drive(32'h3F800001, 32'h3FC00000, 32'h3FC00002, 3'b000, "R4 tie to even up");
    drive(32'h3F800003, 32'h3FC00000, 32'h3FC00004, 3'b000, "R4 tie to even stays");
    drive(32'h3F800001, 32'h3F800001, 32'h3F800002, 3'b000, "R4 below half truncates");
    drive(32'h3F7FFFFE, 32'h3F800001, 32'h3F800000, 3'b000, "R5 round carry renormalizes");
    drive(32'h7EFFFFFE, 32'h3F800001, 32'h7F000000, 3'b000, "R5 carry to top finite");
    drive(32'h7F7FFFFE, 32'h3F800001, 32'h7F800000, 3'b100, "R6 overflow by rounding carry");
    drive(32'h7F000000, 32'h40000000, 32'h7F800000, 3'b100, "R6 plain overflow");
    drive(32'hFF000000, 32'h40000000, 32'hFF800000, 3'b100, "R6 negative overflow");
    idle(2);
    drive(32'h00800000, 32'h3F800000, 32'h00800000, 3'b000, "R7 smallest normal kept");
    drive(32'h80800000, 32'h3F000000, 32'h80000000, 3'b010, "R7 negative underflow");
    drive(32'h00800000, 32'h00800000, 32'h00000000, 3'b010, "R7 deep underflow");
    drive(32'h00000001, 32'h3F800000, 32'h00000000, 3'b000, "R8 subnormal as zero");
    drive(32'h807FFFFF, 32'h40000000, 32'h80000000, 3'b000, "R8 signed subnormal");
    drive(32'h00400000, 32'h7F800000, 32'h7FC00000, 3'b001, "R8 subnormal times inf");
    drive(32'h7FC00000, 32'h3F800000, 32'h7FC00000, 3'b000, "R9 quiet nan input");
    drive(32'h40000000, 32'hFF800001, 32'h7FC00000, 3'b000, "R9 other nan input");
    drive(32'h7F800001, 32'h00000000, 32'h7FC00000, 3'b000, "R9 nan times zero");
    drive(32'h00000000, 32'h7F800000, 32'h7FC00000, 3'b001, "R10 zero times inf");
    drive(32'hFF800000, 32'h80000000, 32'h7FC00000, 3'b001, "R10 inf times zero");
    drive(32'h7F800000, 32'hC0000000, 32'hFF800000, 3'b000, "R11 inf times finite");
    drive(32'hFF800000, 32'hFF800000, 32'h7F800000, 3'b000, "R11 inf times inf");
    drive(32'h80000000, 32'h40A00000, 32'h80000000, 3'b000, "R11 zero times finite");
    idle(3);

    applied++;
    if (sb.size() != 0 || out_valid !== 1'b0) begin
      bad++;
      $display("FAIL R1 drain: actual pending=%0d v=%b expected 0 0", sb.size(), out_valid);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule